// File: doc/BRIEF.md
# Write-Through Data Cache with Store Buffer

This block is a direct-mapped, one-word-per-line data cache that keeps main memory current on every store. Stores do not wait for memory: each accepted store is parked as an address/data pair in a small first-in first-out buffer, and the buffer empties itself to memory in the background while the processor keeps issuing loads and stores. Loads that find their word in the cache return it in the same cycle without touching memory. A load that misses fetches the word from memory and installs it in its line, but the fetch is held back while the buffer still holds a store to that same address.

The processor side is a request port with a combinational stall. The processor raises `cpu_req` with its operation, address and store data, and holds all of them unchanged while `cpu_stall` is high. The operation completes in the first cycle where `cpu_req` is high and `cpu_stall` is low. For a load, the word is on `cpu_rdata` in that cycle. The memory side is a single request/acknowledge port that carries both buffer drains and line refills, one word per transfer.

Top module: `wt_cache`

## Requirements
- R1: After reset every line is invalid, so the first load to any address misses. Out of reset, `cpu_stall` and `mem_req` are low.
- R2: A load whose line is valid and whose tag matches completes in the cycle it is presented, with `cpu_stall` low. It returns the value of the most recent store to that address, or the memory content if no store was made. It starts no memory read.
- R3: A load that misses holds `cpu_stall` high and starts exactly one memory read of its own address. The word returned with `mem_ack` is written into line `addr[INDEX_W-1:0]`, with tag `addr[ADDR_W-1:INDEX_W]`, and the load then completes.
- R4: A store is accepted in the cycle it is presented whenever the buffer holds fewer than DEPTH entries, with `cpu_stall` low, and its address/data pair enters the buffer.
- R5: A store that hits also updates the cached word. A store that misses leaves the cache untouched, so a later load of that address still misses.
- R6: Buffered stores reach memory as memory writes (`mem_we`=1), one per store, in the order the stores were accepted, each carrying that store's address and data. A memory write is only started while the buffer holds an entry.
- R7: While the buffer holds DEPTH entries, a store is stalled until an entry has drained. The buffer never holds more than DEPTH entries.
- R8: A refill read for an address is not started while the buffer holds a store to that same address; other entries may drain first. The loaded value therefore reflects every earlier store.
- R9: At most one memory transfer is outstanding. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay unchanged from the raising of `mem_req` until the `mem_ack` cycle, and `mem_req` is low in the cycle after `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Load data, valid when a load completes |
| cpu_stall | output | 1 | Access cannot complete this cycle |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = buffer drain write, 0 = refill read |
| mem_addr | output | ADDR_W | Word address of the transfer |
| mem_wdata | output | DATA_W | Write data of a drain |
| mem_ack | input | 1 | One-cycle completion of the pending transfer |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` on a read |

## Verification
The bench builds the block with its defaults: 12-bit word addresses, 32-bit data, eight lines and a four-entry buffer. Processor addresses are drawn from the range 0 to 31, so each line is contended by four addresses. Evictions, store misses that later miss on load, and loads that land on a still-buffered store therefore all occur often. Memory latency is varied between one and eight cycles. The slow settings let bursts of stores fill all four buffer slots and hit the full-buffer stall, and let a load of a just-stored address wait behind its pending drain.

// File: rtl/wt_cache.sv
module wt_cache #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 3,
  parameter int DEPTH   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  localparam int TAG_W = ADDR_W - INDEX_W;
  localparam int LINES = 1 << INDEX_W;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LINES-1:0] line_vld;
  logic [TAG_W-1:0] line_tag [LINES];
  logic [DATA_W-1:0] line_dat [LINES];

  logic [ADDR_W-1:0] wb_addr [DEPTH];
  logic [DATA_W-1:0] wb_data [DEPTH];
  logic [DEPTH-1:0]  wb_vld;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  logic [INDEX_W-1:0] idx, fill_idx;
  logic [TAG_W-1:0]   tag;
  logic hit, full, empty, conflict;
  logic store_go, load_miss, issue_rd, issue_wr, done, pop, fill;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign idx      = cpu_addr[INDEX_W-1:0];
  assign tag      = cpu_addr[ADDR_W-1:INDEX_W];
  assign fill_idx = mem_addr[INDEX_W-1:0];
  assign hit      = line_vld[idx] && (line_tag[idx] == tag);
  assign full     = &wb_vld;
  assign empty    = ~|wb_vld;

  always_comb begin
    conflict = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (wb_vld[i] && wb_addr[i] == cpu_addr) conflict = 1'b1;
  end

  assign cpu_stall = cpu_req && (cpu_we ? full : !hit);
  assign cpu_rdata = line_dat[idx];

  assign store_go  = cpu_req && cpu_we && !full;
  assign load_miss = cpu_req && !cpu_we && !hit;
  assign issue_rd  = !mem_req && load_miss && !conflict;
  assign issue_wr  = !mem_req && !issue_rd && !empty;
  assign done      = mem_req && mem_ack;
  assign pop       = done && mem_we;
  assign fill      = done && !mem_we;

  always_ff @(posedge clk) begin
    if (!rst_n) line_vld <= '0;
    else if (fill) line_vld[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      line_tag[fill_idx] <= mem_addr[ADDR_W-1:INDEX_W];
      line_dat[fill_idx] <= mem_rdata;
    end else if (store_go && hit) begin
      line_dat[idx] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_vld <= '0;
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (pop) begin
        wb_vld[rd_ptr] <= 1'b0;
        rd_ptr <= step(rd_ptr);
      end
      if (store_go) begin
        wb_vld[wr_ptr] <= 1'b1;
        wr_ptr <= step(wr_ptr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (store_go) begin
      wb_addr[wr_ptr] <= cpu_addr;
      wb_data[wr_ptr] <= cpu_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (done) begin
      mem_req <= 1'b0;
    end else if (issue_rd) begin
      mem_req  <= 1'b1;
      mem_we   <= 1'b0;
      mem_addr <= cpu_addr;
    end else if (issue_wr) begin
      mem_req   <= 1'b1;
      mem_we    <= 1'b1;
      mem_addr  <= wb_addr[rd_ptr];
      mem_wdata <= wb_data[rd_ptr];
    end
  end

endmodule

// File: rtl/wt_cache_chk.sv
module wt_cache_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_stall,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack
);

  localparam int CW = $clog2(DEPTH + 1) + 1;

  logic [CW-1:0] pend;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else pend <= pend + CW'(cpu_req && cpu_we && !cpu_stall) - CW'(mem_req && mem_ack && mem_we);
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pend <= CW'(DEPTH));

  // R7
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_we && pend == CW'(DEPTH) |-> cpu_stall);

  // R4
  store_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_we && pend < CW'(DEPTH) |-> !cpu_stall);

  // R6
  drain_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> pend != '0);

  // R9
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  // R9
  release_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |=> !mem_req);

  // R3
  refill_for_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) && !mem_we |-> cpu_req && !cpu_we && cpu_stall);

endmodule

bind wt_cache wt_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_stall(cpu_stall),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack)
);

// File: tb/wt_cache_bench.sv
module wt_cache_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int INDEX_W = 3;
  localparam int DEPTH = 4;
  localparam int LINES = 1 << INDEX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic [DATA_W-1:0] cpu_rdata;
  logic cpu_stall, mem_req, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;

  wt_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W), .DEPTH(DEPTH)) u_wt_cache (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic nxt_req = 1'b0, nxt_we = 1'b0;
  logic [ADDR_W-1:0] nxt_addr = '0;
  logic [DATA_W-1:0] nxt_wdata = '0;
  bit op_done = 1'b0;

  int q_a[$];
  logic [DATA_W-1:0] q_d[$];
  logic [DATA_W-1:0] golden[int];
  logic [DATA_W-1:0] mem[int];
  bit cl_v[LINES];
  int cl_a[LINES];
  int lat_max = 3, wcnt = 0, lat = 1;
  int unsigned seed = 32'd7;
  bit prev_req = 1'b0, prev_ack = 1'b0, prev_we = 1'b0;
  logic [ADDR_W-1:0] prev_addr = '0;
  logic [DATA_W-1:0] prev_data = '0;

  function automatic logic [DATA_W-1:0] initv(int a);
    return DATA_W'(a) * 32'h9E37 + 32'h1234;
  endfunction
  function automatic logic [DATA_W-1:0] memv(int a);
    return mem.exists(a) ? mem[a] : initv(a);
  endfunction
  function automatic logic [DATA_W-1:0] goldv(int a);
    return golden.exists(a) ? golden[a] : initv(a);
  endfunction
  function automatic bit cached(int a);
    return cl_v[a % LINES] && cl_a[a % LINES] == a;
  endfunction
  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cpu_req = nxt_req; cpu_we = nxt_we; cpu_addr = nxt_addr; cpu_wdata = nxt_wdata;
      mem_ack = 1'b0;
      if (mem_req) begin
        wcnt++;
        if (wcnt >= lat) begin
          mem_ack = 1'b1;
          mem_rdata = mem_we ? '0 : memv(int'(mem_addr));
          wcnt = 0;
          lat = 1 + int'(rnd() % lat_max);
        end
      end else wcnt = 0;
      #1;
      if (prev_req && !prev_ack)
        chk(mem_req && mem_we == prev_we && mem_addr == prev_addr && (!prev_we || mem_wdata == prev_data),
            "R9", "request fields held until ack", {31'd0, mem_req}, 32'd1);
      if (prev_req && prev_ack)
        chk(!mem_req, "R9", "request dropped after ack", {31'd0, mem_req}, 32'd0);
      if (mem_req && !mem_we && !prev_req) begin
        chk(!cached(int'(mem_addr)), "R2", "read started for a cached word", 32'(mem_addr), 32'hFFFFFFFF);
        begin
          bit clash = 1'b0;
          foreach (q_a[k]) if (q_a[k] == int'(mem_addr)) clash = 1'b1;
          chk(!clash, "R8", "refill read while same address buffered", 32'(mem_addr), 32'hFFFFFFFF);
        end
        chk(cpu_req && !cpu_we && cpu_addr == mem_addr, "R3", "refill address", 32'(mem_addr), 32'(cpu_addr));
      end
      if (mem_req && mem_we && !prev_req)
        chk(q_a.size() > 0, "R6", "drain with empty buffer", 32'(q_a.size()), 32'd1);
      if (cpu_req) begin
        if (cpu_we)
          chk(cpu_stall == (q_a.size() == DEPTH), "R4/R7", "store stall", {31'd0, cpu_stall},
              {31'd0, q_a.size() == DEPTH});
        else
          chk(cpu_stall == !cached(int'(cpu_addr)), "R1/R2/R3/R5", "load stall", {31'd0, cpu_stall},
              {31'd0, !cached(int'(cpu_addr))});
      end
      if (cpu_req && !cpu_stall && !cpu_we)
        chk(cpu_rdata == goldv(int'(cpu_addr)), "R2/R8", "load data", cpu_rdata, goldv(int'(cpu_addr)));
      if (cpu_req && !cpu_stall && cpu_we) begin
        q_a.push_back(int'(cpu_addr));
        q_d.push_back(cpu_wdata);
        golden[int'(cpu_addr)] = cpu_wdata;
      end
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          if (q_a.size() == 0) chk(1'b0, "R6", "write with empty buffer", 32'(mem_addr), 32'd0);
          else begin
            chk(q_a[0] == int'(mem_addr) && q_d[0] == mem_wdata, "R6", "drain order/content",
                mem_wdata, q_d[0]);
            mem[q_a[0]] = q_d[0];
            void'(q_a.pop_front());
            void'(q_d.pop_front());
          end
        end else begin
          cl_v[int'(mem_addr) % LINES] = 1'b1;
          cl_a[int'(mem_addr) % LINES] = int'(mem_addr);
        end
      end
      prev_req = mem_req; prev_ack = mem_ack; prev_we = mem_we;
      prev_addr = mem_addr; prev_data = mem_wdata;
      if (cpu_req && !cpu_stall) begin
        nxt_req = 1'b0;
        op_done = 1'b1;
      end
    end
  end

  task automatic op(bit we, int a, logic [DATA_W-1:0] d);
    nxt_we = we; nxt_addr = ADDR_W'(a); nxt_wdata = d; op_done = 1'b0; nxt_req = 1'b1;
    while (!op_done) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog run did not complete");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!mem_req, "R1", "mem_req after reset", {31'd0, mem_req}, 32'd0);
    chk(!cpu_stall, "R1", "stall after reset", {31'd0, cpu_stall}, 32'd0);
    @(posedge clk);
    // R1 R3: first load misses; R2: second hits
    op(0, 5, 0);
    op(0, 5, 0);
    // R5: store hit updates, store miss does not allocate
    op(1, 5, 32'hA5A5_0001);
    op(0, 5, 0);
    op(1, 13, 32'hBEEF_0013);
    op(0, 5, 0);
    op(0, 13, 0);
    op(0, 5, 0);
    // R7: fill the buffer behind slow memory
    lat_max = 8;
    for (int i = 0; i < 10; i++) op(1, 40 + i, 32'hC000_0000 + 32'(i));
    // R8: load right behind a buffered store to the same word
    op(1, 20, 32'hD00D_0020);
    op(0, 20, 0);
    op(1, 21, 32'h1);
    op(1, 22, 32'h2);
    op(1, 21, 32'h3);
    op(0, 21, 0);
    // mixed traffic
    for (int i = 0; i < 1500; i++) begin
      int unsigned r;
      r = rnd();
      if (i % 300 == 0) lat_max = 1 + int'(r % 8);
      op((r % 3) == 0, int'((r >> 4) % 32), 32'(rnd()));
    end
    repeat (100) @(posedge clk);
    chk(q_a.size() == 0, "R6", "buffer drained at end", 32'(q_a.size()), 32'd0);
    finish_run();
  end

endmodule